// File: doc/BRIEF.md
# Fall-through bubble FIFO buffer

This block is an elastic first-in/first-out buffer made of a chain of word stages (16 by default, each 4 bits wide). Every stage has a one-bit occupancy marker. A stage that is vacant takes the word held by the stage before it, sets its own marker and empties that stage, all in one clock edge. As a result, words fall through toward the output end and vacancies drift back toward the input end. No read or write pointer is involved.

The writer watches `in_ready`, which is high while the first stage is vacant, and pulses `push` to load `push_data`. The reader watches `out_valid`, which is high while the last stage holds a word. It reads `pop_data` and pulses `pop` to remove that word. Latency depends on how full the chain is. A word written into an empty buffer needs DEPTH-1 cycles to reach the output. A vacancy made at the output of a full buffer needs the same time to reach the input. Everything runs on one clock with a synchronous reset.

Top module: `bubble_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, every marker is cleared. After that edge `in_ready` is 1 and `out_valid` is 0.
- R2: If `push` is high at an edge where `in_ready` is 1, the word on `push_data` is stored in the first stage and that stage becomes occupied.
- R3: If `push` is high at an edge where `in_ready` is 0, nothing is stored and no word already held changes. The number of words held changes by exactly (push accepted) minus (pop accepted) at each edge.
- R4: A word moves at most one stage per edge, and only into a stage that was vacant before the edge. A word written into an empty buffer raises `out_valid` exactly DEPTH-1 (15) edges after the edge that wrote it.
- R5: `pop_data` always shows the word in the last stage. `out_valid` is high exactly when that stage is occupied. A word that has not been popped stays on `pop_data`, unchanged.
- R6: If `pop` is high at an edge where `out_valid` is 1, the last stage is emptied and later words advance. In a full buffer, `in_ready` goes high exactly DEPTH-1 (15) edges after the popping edge.
- R7: If `pop` is high at an edge where `out_valid` is 0, nothing happens, and a word written later is the only word delivered.
- R8: The buffer holds DEPTH (16) words. Once 16 words are held and have settled, `in_ready` stays 0 until a word is popped.
- R9: Words leave in the order they were accepted, for any interleaving of pushes and pops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Shift-in strobe |
| push_data | input | 4 | Word to write |
| in_ready | output | 1 | First stage vacant, so a push is accepted |
| pop | input | 1 | Shift-out strobe |
| pop_data | output | 4 | Word in the last stage |
| out_valid | output | 1 | Last stage holds a word |

## Verification
A marker that is set wrongly shows up at the ports as a duplicated or lost word. This reaches `pop_data` at most DEPTH-1 edges later, as the bad slot travels toward the output. A stage that skips its predecessor's check breaks the exact 15-cycle fall-through and bubble-back latencies, which the bench measures to the cycle. A miscount of occupancy shows up as a capacity other than 16 or as an extra word after a write into a full buffer.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  // A vacant stage takes the word offered by its upstream neighbour.
  function automatic logic stage_take(input logic own_full, input logic up_full);
    return up_full && !own_full;
  endfunction

  // Next marker from the current marker and the two local events.
  function automatic logic next_marker(input logic own_full, input logic take, input logic give);
    if (take) return 1'b1;
    if (give) return 1'b0;
    return own_full;
  endfunction
endpackage

// File: rtl/bfifo_stage.sv
module bfifo_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_full,
  input  logic [W-1:0] up_data,
  input  logic         down_take,
  output logic         full,
  output logic [W-1:0] data,
  output logic         take
);
  import bfifo_pkg::*;

  assign take = stage_take(full, up_full);

  always_ff @(posedge clk) begin
    if (rst) full <= 1'b0;
    else     full <= next_marker(full, take, down_take);
    if (take) data <= up_data;
  end

  // R4: a vacant stage offered a word captures it at the next edge
  assert_take_R4: assert property (@(posedge clk) disable iff (rst)
    (up_full && !full) |=> (full && data == $past(up_data)));

  // R4: a stage cannot fill unless its neighbour held a word
  assert_no_skip_R4: assert property (@(posedge clk) disable iff (rst)
    (!full && !up_full) |=> !full);

  // R5: a word not handed on stays put
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (full && !down_take) |=> (full && $stable(data)));
endmodule

// File: rtl/bfifo_chain.sv
module bfifo_chain #(
  parameter int W     = 4,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         feed,
  input  logic [W-1:0] feed_data,
  input  logic         drain,
  output logic [DEPTH-1:0] markers,
  output logic [W-1:0] tail_data,
  output logic         head_take
);
  logic [W-1:0] stage_data [DEPTH];
  logic [DEPTH-1:0] takes;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic         up_f;
    logic [W-1:0] up_d;
    logic         dn_t;
    if (i == 0) begin : g_head
      assign up_f = feed;
      assign up_d = feed_data;
    end else begin : g_body
      assign up_f = markers[i-1];
      assign up_d = stage_data[i-1];
    end
    if (i == DEPTH - 1) begin : g_tail
      assign dn_t = drain && markers[i];
    end else begin : g_inner
      assign dn_t = takes[i+1];
    end
    bfifo_stage #(.W(W)) u_stage (
      .clk(clk), .rst(rst),
      .up_full(up_f), .up_data(up_d), .down_take(dn_t),
      .full(markers[i]), .data(stage_data[i]), .take(takes[i])
    );
  end

  assign tail_data = stage_data[DEPTH-1];
  assign head_take = takes[0];
endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         in_ready,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         out_valid
);
  logic [DEPTH-1:0] markers;
  logic             accepted;
  logic             popped;
  logic             armed;

  bfifo_chain #(.W(W), .DEPTH(DEPTH)) u_chain (
    .clk(clk), .rst(rst),
    .feed(push), .feed_data(push_data), .drain(pop),
    .markers(markers), .tail_data(pop_data), .head_take(accepted)
  );

  assign in_ready  = !markers[0];
  assign out_valid = markers[DEPTH-1];
  assign popped    = pop && out_valid;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R3, R7: occupancy changes only through accepted pushes and pops
  assert_count_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    $countones(markers) == $past($countones(markers)) + $past(int'(accepted)) - $past(int'(popped)));

  // R1: reset leaves the chain empty
  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> (markers == '0));
endmodule

// File: tb/test_bubble_fifo.sv
module test_bubble_fifo;
  localparam int W = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push = 1'b0;
  logic [W-1:0] push_data = '0;
  logic in_ready;
  logic pop = 1'b0;
  logic [W-1:0] pop_data;
  logic out_valid;

  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] q [$];
  logic [W-1:0] seed = 4'h3;

  always #2.5 clk = ~clk;

  bubble_fifo #(.W(W), .DEPTH(DEPTH)) i_bubble_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .in_ready(in_ready), .pop(pop), .pop_data(pop_data), .out_valid(out_valid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] next_word();
    seed = seed * 4'd5 + 4'd7;
    return seed;
  endfunction

  // One cycle of traffic: push and pop only when the flags allow, with model bookkeeping.
  task automatic cycle(input logic want_push, input logic want_pop, input string tag);
    push = want_push && in_ready;
    pop  = want_pop && out_valid;
    if (push) begin
      push_data = next_word();
      q.push_back(push_data);
    end
    if (pop) begin
      check(q.size() > 0, tag, q.size(), 1);
      if (q.size() > 0) begin
        check(pop_data == q[0], tag, pop_data, q[0]);
        void'(q.pop_front());
      end
    end
    tick();
    push = 1'b0;
    pop  = 1'b0;
  endtask

  task automatic drain_all(input string tag);
    int idle = 0;
    while (idle < 2 * DEPTH) begin
      if (out_valid) idle = 0; else idle++;
      cycle(1'b0, 1'b1, tag);
    end
    check(q.size() == 0, tag, q.size(), 0);
    check(out_valid == 1'b0, tag, out_valid, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    q.delete();
  endtask

  task automatic t_latency();
    int n = 0;
    logic [W-1:0] w;
    cycle(1'b1, 1'b0, "R2 write");
    w = q[0];
    check(in_ready == 1'b0, "R2 stage0 filled", in_ready, 0);
    while (!out_valid && n < 4 * DEPTH) begin tick(); n++; end
    check(n == DEPTH - 1, "R4 fall-through latency", n, DEPTH - 1);
    check(pop_data == w, "R5 pop_data", pop_data, w);
    repeat (3) tick();
    check(out_valid && pop_data == w, "R5 hold", pop_data, w);
    cycle(1'b0, 1'b1, "R6 pop");
    check(out_valid == 1'b0, "R6 emptied", out_valid, 0);
  endtask

  task automatic t_empty_pop();
    pop = 1'b1;
    repeat (3) tick();
    pop = 1'b0;
    check(out_valid == 1'b0, "R7 no word", out_valid, 0);
    cycle(1'b1, 1'b0, "R7 write");
    repeat (DEPTH) tick();
    check(out_valid == 1'b1, "R7 word arrives", out_valid, 1);
    drain_all("R7 single word");
  endtask

  task automatic t_fill();
    int idle = 0;
    int held;
    int n = 0;
    while (idle < 2 * DEPTH) begin
      if (in_ready) idle = 0; else idle++;
      cycle(1'b1, 1'b0, "R8 fill");
    end
    check(q.size() == DEPTH, "R8 capacity", q.size(), DEPTH);
    check(in_ready == 1'b0, "R8 full", in_ready, 0);
    held = q.size();
    push = 1'b1;
    for (int k = 0; k < 4; k++) begin
      push_data = 4'(k + 9);
      tick();
    end
    push = 1'b0;
    check(q.size() == held, "R3 model", q.size(), held);
    cycle(1'b0, 1'b1, "R9 first out");
    while (!in_ready && n < 4 * DEPTH) begin tick(); n++; end
    check(n == DEPTH - 1, "R6 bubble-back latency", n, DEPTH - 1);
    drain_all("R3 R9 drain after full");
  endtask

  task automatic t_stream();
    for (int k = 0; k < 300; k++)
      cycle((k % 3) != 0, (k % 5) < 2, "R9 stream");
    drain_all("R9 stream drain");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_empty_pop();
    t_fill();
    t_stream();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule